// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block arbitrates five interrupt sources for a small processor core: external line 0, timer 0 overflow, external line 1, timer 1 overflow and the serial port. Software programs an 8-bit enable register and an 8-bit priority register through a simple register port. When the core reports an instruction boundary, the controller picks the most urgent enabled request that the current nesting state allows. One cycle later it issues a single-cycle take pulse with that source's fixed vector address and a one-hot acknowledge that lets the source clear its flag.

There are two priority levels. One in-service bit is kept per level. A high-level request may interrupt a low-level handler. A high-level handler cannot be interrupted. A low-level request waits until no handler of either level is active. The core pulses a return input when a handler finishes, and this clears the in-service bit of the highest active level.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After synchronous reset, both registers read 0x00 and `take_o` stays low, even when every request line is high.
- R2: Register select 0 is the enable register and select 1 is the priority register. Enable keeps bits 7 and 4..0. Priority keeps bits 4..0. All other bits read back as zero. A write is visible on `reg_rdata_o` from the next cycle on.
- R3: No request is taken while enable bit 7 (global enable) is 0.
- R4: A source is taken only if its own enable bit is 1: bit 0 for external 0, bit 1 for timer 0, bit 2 for external 1, bit 3 for timer 1, bit 4 for serial.
- R5: Each take drives `vector_o` to the source's fixed address (external 0 0x03, timer 0 0x0B, external 1 0x13, timer 1 0x1B, serial 0x23). In the same cycle `ack_o` is one-hot, with the bit index given in R4. `ack_o` is zero in every cycle without a take.
- R6: Among pending requests of the same level, the winner is the lowest index: external 0, then timer 0, external 1, timer 1, serial.
- R7: A priority bit of 1 makes that source high level. An eligible high-level request wins over any low-level request, whatever their order.
- R8: A take is decided only in a cycle where `boundary_i` is 1. `take_o` is a one-cycle pulse in the following cycle.
- R9: While only a low-level handler is in service, an eligible high-level request is still taken.
- R10: While a high-level handler is in service, nothing is taken. While any handler is in service, no low-level request is taken.
- R11: A pulse on `reti_i` clears the high in-service bit if it is set, and otherwise the low one. A low handler preempted by a high one therefore stays active after one return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 5 | Pending request per source, index order as in R4 |
| boundary_i | input | 1 | Core is at an instruction boundary |
| reti_i | input | 1 | Current handler has returned |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0 selects enable, 1 selects priority |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Read data of the selected register |
| take_o | output | 1 | One-cycle interrupt take pulse |
| vector_o | output | 8 | Vector address of the taken source |
| ack_o | output | 5 | One-hot acknowledge to the taken source |

## Verification
The assertions assume that the core returns only from handlers it has entered. They also assume that a source drops its request once it sees its acknowledge, so a stale level is never taken twice. The stimulus models this: it lowers each request bit in the cycle after the matching take, and it pulses the return input only while a handler is active. Writes to the priority register are made only while no handler of a level they would move is in service.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int NSRC      = 5;
    localparam int IDXW      = $clog2(NSRC);
    localparam int DW        = 8;
    localparam int GLOBAL_EN = 7;
    localparam logic [DW-1:0] VEC_BASE = 8'h03;
    localparam int VEC_SHIFT = 3;
    localparam logic [DW-1:0] EN_KEEP  = 8'h9F;
    localparam logic [DW-1:0] PRI_KEEP = 8'h1F;

    typedef struct packed {
        logic            hit;
        logic [IDXW-1:0] idx;
    } pick_t;

    typedef enum logic {
        SEL_ENABLE   = 1'b0,
        SEL_PRIORITY = 1'b1
    } reg_sel_e;

    function automatic pick_t first_set(input logic [NSRC-1:0] v);
        pick_t p;
        p = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (v[i]) begin
                p.hit = 1'b1;
                p.idx = IDXW'(i);
            end
        end
        return p;
    endfunction

    function automatic logic [DW-1:0] vec_of(input logic [IDXW-1:0] idx);
        return VEC_BASE + (DW'(idx) << VEC_SHIFT);
    endfunction

endpackage

// File: rtl/irq_regs.sv
module irq_regs
    import irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr,
    input  logic            sel,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   rdata,
    output logic            gen,
    output logic [NSRC-1:0] src_en,
    output logic [NSRC-1:0] src_pri
);
    logic [DW-1:0] en_q;
    logic [DW-1:0] pri_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= '0;
            pri_q <= '0;
        end else if (wr) begin
            if (reg_sel_e'(sel) == SEL_ENABLE) en_q  <= wdata & EN_KEEP;
            else                               pri_q <= wdata & PRI_KEEP;
        end
    end

    assign rdata   = (reg_sel_e'(sel) == SEL_ENABLE) ? en_q : pri_q;
    assign gen     = en_q[GLOBAL_EN];
    assign src_en  = en_q[NSRC-1:0];
    assign src_pri = pri_q[NSRC-1:0];
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_pkg::*;
(
    input  logic [NSRC-1:0] req,
    input  logic            gen,
    input  logic [NSRC-1:0] src_en,
    input  logic [NSRC-1:0] src_pri,
    input  logic            isr_hi,
    input  logic            isr_lo,
    output pick_t           win,
    output logic            win_high
);
    logic [NSRC-1:0] elig;
    pick_t           hi_p;
    pick_t           lo_p;

    assign elig = req & src_en & {NSRC{gen}};
    assign hi_p = first_set(elig & src_pri);
    assign lo_p = first_set(elig & ~src_pri);

    always_comb begin
        win      = '0;
        win_high = 1'b0;
        if (hi_p.hit && !isr_hi) begin
            win      = hi_p;
            win_high = 1'b1;
        end else if (lo_p.hit && !isr_hi && !isr_lo) begin
            win = lo_p;
        end
    end
endmodule

// File: rtl/irq_nest.sv
module irq_nest (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    input  logic fire_high,
    input  logic reti,
    output logic isr_hi,
    output logic isr_lo
);
    logic hi_d;
    logic lo_d;

    always_comb begin
        hi_d = isr_hi;
        lo_d = isr_lo;
        if (reti) begin
            if (isr_hi) hi_d = 1'b0;
            else        lo_d = 1'b0;
        end
        if (fire) begin
            if (fire_high) hi_d = 1'b1;
            else           lo_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            isr_hi <= 1'b0;
            isr_lo <= 1'b0;
        end else begin
            isr_hi <= hi_d;
            isr_lo <= lo_d;
        end
    end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
    import irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] req_i,
    input  logic            boundary_i,
    input  logic            reti_i,
    input  logic            reg_wr_i,
    input  logic            reg_sel_i,
    input  logic [DW-1:0]   reg_wdata_i,
    output logic [DW-1:0]   reg_rdata_o,
    output logic            take_o,
    output logic [DW-1:0]   vector_o,
    output logic [NSRC-1:0] ack_o
);
    logic            gen_w;
    logic [NSRC-1:0] en_w;
    logic [NSRC-1:0] pri_w;
    logic            isr_hi_w;
    logic            isr_lo_w;
    pick_t           win_w;
    logic            win_high_w;
    logic            fire_w;

    irq_regs u_regs (
        .clk(clk), .rst(rst), .wr(reg_wr_i), .sel(reg_sel_i),
        .wdata(reg_wdata_i), .rdata(reg_rdata_o),
        .gen(gen_w), .src_en(en_w), .src_pri(pri_w)
    );

    irq_arbiter u_arb (
        .req(req_i), .gen(gen_w), .src_en(en_w), .src_pri(pri_w),
        .isr_hi(isr_hi_w), .isr_lo(isr_lo_w),
        .win(win_w), .win_high(win_high_w)
    );

    assign fire_w = boundary_i & win_w.hit;

    irq_nest u_nest (
        .clk(clk), .rst(rst), .fire(fire_w), .fire_high(win_high_w),
        .reti(reti_i), .isr_hi(isr_hi_w), .isr_lo(isr_lo_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            take_o   <= 1'b0;
            vector_o <= '0;
            ack_o    <= '0;
        end else begin
            take_o <= fire_w;
            if (fire_w) begin
                vector_o <= vec_of(win_w.idx);
                ack_o    <= NSRC'(1) << win_w.idx;
            end else begin
                ack_o <= '0;
            end
        end
    end
endmodule

// File: rtl/irq_vec_ctrl_chk.sv
module irq_vec_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       boundary_i,
    input logic       take_o,
    input logic [7:0] vector_o,
    input logic [4:0] ack_o,
    input logic       gen,
    input logic       isr_hi,
    input logic       isr_lo
);
    assert_ack_onehot_R5: assert property (@(posedge clk) disable iff (rst)
        take_o |-> $onehot(ack_o));

    assert_ack_idle_R5: assert property (@(posedge clk) disable iff (rst)
        !take_o |-> (ack_o == 5'b0));

    assert_vector_match_R5: assert property (@(posedge clk) disable iff (rst)
        take_o |-> (vector_o == (ack_o[0] ? 8'h03 : ack_o[1] ? 8'h0B :
                                 ack_o[2] ? 8'h13 : ack_o[3] ? 8'h1B : 8'h23)));

    assert_at_boundary_R8: assert property (@(posedge clk) disable iff (rst)
        take_o |-> $past(boundary_i));

    assert_global_gate_R3: assert property (@(posedge clk) disable iff (rst)
        take_o |-> $past(gen));

    assert_high_unbroken_R10: assert property (@(posedge clk) disable iff (rst)
        take_o |-> !$past(isr_hi));

    assert_level_marked_R9: assert property (@(posedge clk) disable iff (rst)
        take_o |-> (isr_hi || isr_lo));
endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .boundary_i(boundary_i), .take_o(take_o),
    .vector_o(vector_o), .ack_o(ack_o), .gen(gen_w),
    .isr_hi(isr_hi_w), .isr_lo(isr_lo_w)
);

// File: tb/sim_irq_vec_ctrl.sv
module sim_irq_vec_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] req_i = '0;
    logic       boundary_i = 1'b0;
    logic       reti_i = 1'b0;
    logic       reg_wr_i = 1'b0;
    logic       reg_sel_i = 1'b0;
    logic [7:0] reg_wdata_i = '0;
    logic [7:0] reg_rdata_o;
    logic       take_o;
    logic [7:0] vector_o;
    logic [4:0] ack_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        int         due;
        bit         take;
        logic [7:0] vec;
        logic [4:0] ack;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    irq_vec_ctrl u0 (
        .clk(clk), .rst(rst), .req_i(req_i), .boundary_i(boundary_i),
        .reti_i(reti_i), .reg_wr_i(reg_wr_i), .reg_sel_i(reg_sel_i),
        .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
        .take_o(take_o), .vector_o(vector_o), .ack_o(ack_o)
    );

    // monitor: compares each expected item in the cycle it falls due
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb.size() > 0 && sb[0].due == cyc) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (take_o !== e.take || ack_o !== e.ack ||
                    (e.take && vector_o !== e.vec)) begin
                    errors++;
                    $display("FAIL %s: take=%0b vec=%h ack=%b expected take=%0b vec=%h ack=%b",
                             e.tag, take_o, vector_o, ack_o, e.take, e.vec, e.ack);
                end
            end
        end
    end

    task automatic push(bit t, logic [7:0] v, logic [4:0] a, string tag);
        exp_t e;
        e.due = cyc + 1; e.take = t; e.vec = v; e.ack = a; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic step(bit b, logic [4:0] r, bit rt, bit t, logic [7:0] v,
                        logic [4:0] a, string tag);
        @(negedge clk);
        reg_wr_i = 1'b0; boundary_i = b; req_i = r; reti_i = rt;
        push(t, v, a, tag);
    endtask

    task automatic wr_reg(bit sel, logic [7:0] d);
        @(negedge clk);
        reg_wr_i = 1'b1; reg_sel_i = sel; reg_wdata_i = d;
        boundary_i = 1'b0; reti_i = 1'b0; req_i = '0;
        push(1'b0, 8'h00, 5'b0, "write");
    endtask

    task automatic rd_chk(bit sel, logic [7:0] exp, string tag);
        @(negedge clk);
        reg_wr_i = 1'b0; reg_sel_i = sel; boundary_i = 1'b0; reti_i = 1'b0;
        push(1'b0, 8'h00, 5'b0, tag);
        #1;
        checks++;
        if (reg_rdata_o !== exp) begin
            errors++;
            $display("FAIL %s: rdata=%h expected %h", tag, reg_rdata_o, exp);
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        rd_chk(1'b0, 8'h00, "R1 enable after reset");
        rd_chk(1'b1, 8'h00, "R1 priority after reset");
        step(1, 5'h1F, 0, 0, 8'h00, 5'h00, "R1 no take after reset");
        // R2: register readback and unimplemented bits
        wr_reg(1'b0, 8'hFF);
        rd_chk(1'b0, 8'h9F, "R2 enable readback");
        wr_reg(1'b1, 8'hFF);
        rd_chk(1'b1, 8'h1F, "R2 priority readback");
        wr_reg(1'b1, 8'h00);
        // R3: global enable off
        wr_reg(1'b0, 8'h1F);
        step(1, 5'h1F, 0, 0, 8'h00, 5'h00, "R3 global off");
        // R4: per-source enable (timer 0 only)
        wr_reg(1'b0, 8'h82);
        step(1, 5'h01, 0, 0, 8'h00, 5'h00, "R4 ext0 disabled");
        step(1, 5'h03, 0, 1, 8'h0B, 5'h02, "R4 R5 timer0 taken");
        step(0, 5'h00, 1, 0, 8'h00, 5'h00, "R4 return");
        // R6: fixed order within low level
        wr_reg(1'b0, 8'h9F);
        step(1, 5'h1C, 0, 1, 8'h13, 5'h04, "R6 R5 ext1 first");
        step(0, 5'h18, 1, 0, 8'h00, 5'h00, "R6 return");
        step(1, 5'h18, 0, 1, 8'h1B, 5'h08, "R6 R5 timer1 next");
        step(0, 5'h10, 1, 0, 8'h00, 5'h00, "R6 return");
        step(1, 5'h10, 0, 1, 8'h23, 5'h10, "R6 R5 serial last");
        step(0, 5'h00, 1, 0, 8'h00, 5'h00, "R6 return");
        // R8: boundary gating
        step(0, 5'h01, 0, 0, 8'h00, 5'h00, "R8 no boundary");
        step(1, 5'h01, 0, 1, 8'h03, 5'h01, "R8 R5 ext0 at boundary");
        // R10: low blocked while low in service
        step(1, 5'h02, 0, 0, 8'h00, 5'h00, "R10 low waits on low");
        // R9: high preempts low handler
        wr_reg(1'b1, 8'h10);
        step(1, 5'h12, 0, 1, 8'h23, 5'h10, "R9 serial high preempts");
        // R10: nothing preempts high
        wr_reg(1'b1, 8'h12);
        step(1, 5'h02, 0, 0, 8'h00, 5'h00, "R10 high blocked by high");
        // R11: return clears highest level only
        step(0, 5'h02, 1, 0, 8'h00, 5'h00, "R11 return high");
        step(1, 5'h02, 0, 1, 8'h0B, 5'h02, "R11 high taken after return");
        step(0, 5'h04, 1, 0, 8'h00, 5'h00, "R11 return high again");
        step(1, 5'h04, 0, 0, 8'h00, 5'h00, "R11 low still in service");
        step(0, 5'h04, 1, 0, 8'h00, 5'h00, "R11 return low");
        step(1, 5'h04, 0, 1, 8'h13, 5'h04, "R11 low taken after both clear");
        step(0, 5'h00, 1, 0, 8'h00, 5'h00, "R11 return");
        // R7: high wins regardless of order
        wr_reg(1'b1, 8'h10);
        step(1, 5'h11, 0, 1, 8'h23, 5'h10, "R7 high serial over ext0");
        step(0, 5'h01, 1, 0, 8'h00, 5'h00, "R7 return");
        step(1, 5'h01, 0, 1, 8'h03, 5'h01, "R7 ext0 afterwards");
        step(0, 5'h00, 1, 0, 8'h00, 5'h00, "R7 return");
        step(0, 5'h00, 0, 0, 8'h00, 5'h00, "idle");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule